// File: doc/BRIEF.md
# Watchdog Timer with Protection Mode

This block watches over the software running on a small controller. A down-counter is loaded with a long timeout. It decrements on each tick of its count source. Software must refresh it before it reaches the end. A refresh is a two-byte unlock on a byte-wide register port: a write of 00h to the refresh register, then a write of FFh. If the counter runs past zero, the block raises a one-cycle interrupt pulse or a sticky reset request, depending on a control bit.

A protection mode hardens the timer. Software can set it but never clear it. It makes four changes together:
- The count source becomes a free-running low-speed oscillator tick.
- The reload value drops to a shorter one.
- Every expiry becomes a reset request.
- The counter keeps running through stop and wait modes.

Without protection, the source is the CPU clock-enable divided by one of two prescale ratios. Counting then pauses in either low-power mode. A build parameter decides whether counting starts by itself after reset or waits for a write to the start register.

Top module: `wdt_guard`

## Requirements
- R1: After reset the count reads all ones (7FFFh at the default width), `irq_pulse` and `rst_req` are low, and protection is off.
- R2: The count decrements by exactly one per count-source tick, and only while running. With `AUTO_START`=1 it runs from reset. With `AUTO_START`=0 it runs after any write to the start register (address 2).
- R3: Without protection, a count-source tick occurs on every 16th `cpu_tick` when control bit 0 is 0, and on every 128th when it is 1. The control register is at address 0.
- R4: With protection, every `losc_tick` is a count-source tick, and `cpu_tick` and the divider bit have no effect.
- R5: Writing 00h to the refresh register (address 1) arms the unlock. A following write of FFh to it reloads the counter. Any other value written to it in between cancels the unlock, and an FFh write with no armed unlock does nothing.
- R6: A reload sets the count to all ones without protection and to `PROT_RELOAD` (0FFFh by default) with protection. Setting protection also reloads the counter.
- R7: Without protection, an underflow with control bit 1 at 0 gives a single-cycle `irq_pulse`. With bit 1 at 1 it sets `rst_req` instead.
- R8: With protection, an underflow always sets `rst_req` and never pulses `irq_pulse`.
- R9: Once set, `rst_req` stays high until `rst_n` is asserted.
- R10: Without protection, counting halts while `stop_mode` or `wait_mode` is high. With protection, neither has any effect.
- R11: Writing control bit 2 as 1 sets protection. A later write with bit 2 at 0 does not clear it.
- R12: The prescaler clears on every reload, so after a refresh the first decrement comes a full divider period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 refresh, 2 start |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | CPU clock enable |
| losc_tick | input | 1 | Low-speed oscillator clock enable |
| stop_mode | input | 1 | Stop mode active |
| wait_mode | input | 1 | Wait mode active |
| irq_pulse | output | 1 | One-cycle watchdog interrupt request |
| rst_req | output | 1 | Sticky watchdog reset request |
| count | output | CNT_W | Current counter value |

## Verification
The assertions assume the following about the block's inputs and parameters:
- `cpu_tick` and `losc_tick` are synchronous enables.
- At most one register write arrives per cycle.
- The reload values are far above zero, so two underflows can never fall on adjacent cycles.

The one-cycle pulse check relies on that last point.

The stimulus keeps within these limits in three ways:
- It drives every input on the falling edge and issues writes one at a time.
- It shrinks the counter width and the protected reload through parameters, so that both unprotected expiry kinds finish inside the run.
- It varies the tick patterns only through the enable inputs, never through the clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] ADDR_CTL   = 2'd0;
  localparam logic [1:0] ADDR_KICK  = 2'd1;
  localparam logic [1:0] ADDR_START = 2'd2;

  localparam logic [7:0] KEY_ARM  = 8'h00;
  localparam logic [7:0] KEY_FIRE = 8'hFF;

  localparam int BIT_DIV  = 0;
  localparam int BIT_ACT  = 1;
  localparam int BIT_PROT = 2;

  typedef struct packed {
    logic prot;
    logic act_rst;
    logic div_hi;
  } ctl_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       sel,
  input  logic [7:0] data,
  output logic       fire
);
  logic armed_q, armed_d;
  logic hit;

  always_comb begin
    hit     = wr_en && sel;
    fire    = hit && (data == KEY_FIRE) && armed_q;
    armed_d = armed_q;
    if (hit) armed_d = (data == KEY_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // a completed unlock is consumed
  p_fire_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q);
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV_LO = 16,
  parameter int DIV_HI = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cpu_tick,
  input  logic div_hi,
  input  logic clear,
  output logic tick
);
  localparam int PW = $clog2(DIV_HI);

  logic [PW-1:0] pre_q, pre_d, lim;
  logic          step;

  always_comb begin
    lim   = div_hi ? PW'(DIV_HI - 1) : PW'(DIV_LO - 1);
    step  = en && cpu_tick;
    tick  = step && (pre_q == lim);
    pre_d = pre_q;
    if (clear)      pre_d = '0;
    else if (tick)  pre_d = '0;
    else if (step)  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  p_tick_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pre_q == '0));
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W       = 15,
  parameter int PROT_RELOAD = 4095
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic             prot_next,
  output logic             under,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rl;

  always_comb begin
    rl    = prot_next ? CNT_W'(PROT_RELOAD) : {CNT_W{1'b1}};
    under = tick && !reload && (cnt_q == '0);
    cnt_d = cnt_q;
    if (reload)         cnt_d = rl;
    else if (under)     cnt_d = rl;
    else if (tick)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= {CNT_W{1'b1}};
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int   CNT_W       = 15,
  parameter int   PROT_RELOAD = 4095,
  parameter int   DIV_LO      = 16,
  parameter int   DIV_HI      = 128,
  parameter logic AUTO_START  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             cpu_tick,
  input  logic             losc_tick,
  input  logic             stop_mode,
  input  logic             wait_mode,
  output logic             irq_pulse,
  output logic             rst_req,
  output logic [CNT_W-1:0] count
);
  ctl_t ctl_q, ctl_d;
  logic run_q, run_d;
  logic irq_q, irq_d;
  logic rst_q, rst_d;
  logic active, pre_en, pre_tick, src_tick;
  logic kick, prot_set, reload, under;

  // register writes
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en && wr_addr == ADDR_CTL) begin
      ctl_d.div_hi  = wr_data[BIT_DIV];
      ctl_d.act_rst = wr_data[BIT_ACT];
      ctl_d.prot    = ctl_q.prot | wr_data[BIT_PROT];
    end
    prot_set = ctl_d.prot && !ctl_q.prot;
    run_d    = run_q | (wr_en && wr_addr == ADDR_START);
  end

  // count source selection
  always_comb begin
    active   = run_q && (ctl_q.prot || !(stop_mode || wait_mode));
    pre_en   = active && !ctl_q.prot;
    src_tick = ctl_q.prot ? (active && losc_tick) : pre_tick;
    reload   = kick || prot_set;
  end

  // expiry action
  always_comb begin
    irq_d = under && !ctl_q.prot && !ctl_q.act_rst;
    rst_d = rst_q | (under && (ctl_q.prot || ctl_q.act_rst));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      run_q <= AUTO_START;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      run_q <= run_d;
      irq_q <= irq_d;
      rst_q <= rst_d;
    end
  end

  wdt_unlock u_unlock (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (wr_addr == ADDR_KICK),
    .data  (wr_data),
    .fire  (kick)
  );

  wdt_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pre_en),
    .cpu_tick (cpu_tick),
    .div_hi   (ctl_q.div_hi),
    .clear    (reload || under),
    .tick     (pre_tick)
  );

  wdt_downcount #(.CNT_W(CNT_W), .PROT_RELOAD(PROT_RELOAD)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (src_tick),
    .reload    (reload),
    .prot_next (ctl_d.prot),
    .under     (under),
    .count     (count)
  );

  assign irq_pulse = irq_q;
  assign rst_req   = rst_q;

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_rst_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
  p_prot_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.prot |=> ctl_q.prot);
  p_prot_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.prot |-> !irq_q);
  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.prot && (stop_mode || wait_mode)) |-> !src_tick);
  p_reload_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count == (ctl_q.prot ? CNT_W'(PROT_RELOAD) : {CNT_W{1'b1}})));
endmodule

// File: tb/sim_wdt_guard.sv
module sim_wdt_guard;
  localparam int W   = 11;
  localparam int PR  = 255;
  localparam int MAX = (1 << W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic cpu_tick = 1'b0, losc_tick = 1'b0;
  logic stop_mode = 1'b0, wait_mode = 1'b0;
  logic irq0, rr0, irq1, rr1;
  logic [W-1:0] cnt0, cnt1;

  wdt_guard #(.CNT_W(W), .PROT_RELOAD(PR), .AUTO_START(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_tick(cpu_tick), .losc_tick(losc_tick), .stop_mode(stop_mode),
    .wait_mode(wait_mode), .irq_pulse(irq0), .rst_req(rr0), .count(cnt0));

  wdt_guard #(.CNT_W(W), .PROT_RELOAD(PR), .AUTO_START(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cpu_tick(cpu_tick), .losc_tick(losc_tick), .stop_mode(stop_mode),
    .wait_mode(wait_mode), .irq_pulse(irq1), .rst_req(rr1), .count(cnt1));

  int tests = 0, fails = 0;
  int cyc = 0;
  int cpu_mode = 0;
  int losc_per = 3;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick generation and watchdog
  always @(negedge clk) begin
    cyc++;
    cpu_tick  = (cpu_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    losc_tick = ((cyc % losc_per) == 0);
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // behavioural reference model of u0
  int m_cnt, m_pre, m_run, m_prot, m_div, m_act, m_arm, m_irq, m_rr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = MAX; m_pre = 0; m_run = 0; m_prot = 0; m_div = 0;
      m_act = 0; m_arm = 0; m_irq = 0; m_rr = 0;
    end else begin
      int n_cnt, n_pre, n_prot, n_arm, lim, tk, go, fire;
      n_cnt = m_cnt; n_pre = m_pre; n_prot = m_prot; n_arm = m_arm; tk = 0;
      fire = 0;
      if (wr_en && wr_addr == 2'd1) begin
        fire  = (wr_data == 8'hFF) && (m_arm != 0);
        n_arm = (wr_data == 8'h00);
      end
      lim = m_div ? 127 : 15;
      go  = m_run && (m_prot || !(stop_mode || wait_mode));
      if (m_prot) tk = go && losc_tick;
      else if (go && cpu_tick) begin
        if (m_pre == lim) begin tk = 1; n_pre = 0; end
        else n_pre = (m_pre + 1) % 128;
      end
      if (wr_en && wr_addr == 2'd0) begin
        if (wr_data[2]) n_prot = 1;
      end
      m_irq = 0;
      if (fire || (n_prot && !m_prot)) begin
        n_cnt = n_prot ? PR : MAX; n_pre = 0;
      end else if (tk) begin
        if (m_cnt == 0) begin
          n_cnt = m_prot ? PR : MAX; n_pre = 0;
          if (!m_prot && !m_act) m_irq = 1; else m_rr = 1;
        end else n_cnt = m_cnt - 1;
      end
      if (wr_en && wr_addr == 2'd0) begin
        m_div = wr_data[0]; m_act = wr_data[1];
      end
      if (wr_en && wr_addr == 2'd2) m_run = 1;
      m_cnt = n_cnt; m_pre = n_pre; m_prot = n_prot; m_arm = n_arm;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      chk("MODEL count", int'(cnt0), m_cnt);
      chk("MODEL irq_pulse", int'(irq0), m_irq);
      chk("MODEL rst_req", int'(rr0), m_rr);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c0, k, seen;
    step(3);
    rst_n = 1'b1;
    chk("R1 count", int'(cnt0), MAX);
    chk("R1 irq_pulse", int'(irq0), 0);
    chk("R1 rst_req", int'(rr0), 0);
    step(100);
    chk("R2 no autostart holds", int'(cnt0), MAX);
    chk("R2 autostart counts", int'(cnt1 < W'(MAX)), 1);

    wr(2'd0, 8'h00);
    wr(2'd2, 8'h5A);
    step(160);
    chk("R2 ten decrements", int'(cnt0), MAX - 10);

    cpu_mode = 1;
    wr(2'd0, 8'h01);
    step(700);
    chk("R3 divide by 128", int'(cnt0), m_cnt);

    stop_mode = 1'b1; c0 = int'(cnt0);
    step(300);
    chk("R10 stop halts", int'(cnt0), c0);
    stop_mode = 1'b0; wait_mode = 1'b1; c0 = int'(cnt0);
    step(300);
    chk("R10 wait halts", int'(cnt0), c0);
    wait_mode = 1'b0;
    cpu_mode = 0;

    wr(2'd0, 8'h00);
    step(40);
    wr(2'd1, 8'hFF);
    chk("R5 unarmed FF ignored", int'(cnt0 == W'(MAX)), 0);
    wr(2'd1, 8'h00); wr(2'd1, 8'h55); wr(2'd1, 8'hFF);
    chk("R5 cancelled unlock", int'(cnt0 == W'(MAX)), 0);
    wr(2'd1, 8'h00); wr(2'd1, 8'hFF);
    chk("R6 refresh reload", int'(cnt0), MAX);
    step(15);
    chk("R12 full period before step", int'(cnt0), MAX);
    step(1);
    chk("R12 first step", int'(cnt0), MAX - 1);

    // interrupt expiry
    wr(2'd1, 8'h00); wr(2'd1, 8'hFF);
    k = 0;
    while (!irq0 && k < 40000) begin @(negedge clk); k++; end
    chk("R7 irq after full timeout", k, 32768);
    chk("R7 no reset request", int'(rr0), 0);
    step(1);
    chk("R7 single-cycle pulse", int'(irq0), 0);

    // reset-request expiry
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00); wr(2'd1, 8'hFF);
    k = 0; seen = 0;
    while (!rr0 && k < 40000) begin @(negedge clk); k++; seen |= irq0; end
    chk("R7 reset action timing", k, 32768);
    chk("R7 no irq in reset action", seen, 0);
    step(100);
    chk("R9 request held", int'(rr0), 1);

    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    chk("R9 cleared by reset", int'(rr0), 0);
    chk("R1 count after reset", int'(cnt0), MAX);

    // protection mode
    wr(2'd2, 8'h00);
    step(5);
    wr(2'd0, 8'h04);
    chk("R6 protection reload", int'(cnt0), PR);
    wr(2'd0, 8'h00);
    cpu_mode = 1;
    stop_mode = 1'b1; wait_mode = 1'b1;
    c0 = int'(cnt0);
    step(30);
    chk("R4 losc ticks counted", c0 - int'(cnt0), 10);
    chk("R10 protected ignores low power", int'(cnt0 < W'(c0)), 1);
    k = 0; seen = 0;
    while (!rr0 && k < 2000) begin @(negedge clk); k++; seen |= irq0; end
    chk("R8 protected expiry resets", int'(rr0), 1);
    chk("R8 no irq when protected", seen, 0);
    chk("R11 protection kept", int'(cnt0), PR);
    stop_mode = 1'b0; wait_mode = 1'b0;
    step(5);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule